// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block turns a 16-bit virtual address into a physical address using a small table of segment descriptors. The two highest address bits pick one of four segments. The other fourteen bits are an offset. The offset is compared with the selected segment's limit. If it is inside the limit, the offset is added to the segment's base to form the physical address. If it is not, the block raises an access fault instead.

A request is presented with `req_valid_i` and `vaddr_i`. The result comes out one clock later on registered outputs. Software can rewrite one descriptor per cycle through a write port that carries an index, a base and a limit. After reset the table holds a fixed default layout, so translation works before any write.

Top module: `seg_xlate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `valid_o`, `fault_o` and `paddr_o` are all zero.
- R2: `vaddr_i[15:14]` selects the segment and `vaddr_i[13:0]` is the offset.
- R3: For a request whose offset is below the segment limit, the cycle after the request shows `valid_o`=1, `fault_o`=0 and `paddr_o` = (base + offset) mod 2^16.
- R4: For a request whose offset is at or above the segment limit, the cycle after the request shows `fault_o`=1, `valid_o`=0 and `paddr_o`=0.
- R5: An offset equal to the limit faults, and an offset of limit-1 translates.
- R6: In the cycle after a clock with no request, `valid_o`=0, `fault_o`=0 and `paddr_o`=0.
- R7: After reset the descriptors are: segment 0 base 0x4000 limit 0x0800; segment 1 base 0x4800 limit 0x1400; segment 2 base 0xF000 limit 0x1000; segment 3 base 0x0000 limit 0x3000.
- R8: A descriptor write with `desc_we_i`=1 replaces entry `desc_idx_i` at the clock edge. A request made in the same cycle as the write uses the old entry. Requests in later cycles use the new entry.
- R9: A descriptor write leaves every other entry unchanged.
- R10: A segment with limit 0 faults for every offset, and a limit of 0x4000 admits every offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| vaddr_i | input | 16 | Virtual address |
| desc_we_i | input | 1 | Descriptor write enable |
| desc_idx_i | input | 2 | Index of the descriptor to write |
| desc_base_i | input | 16 | New base value |
| desc_limit_i | input | 15 | New limit value (exclusive bound) |
| valid_o | output | 1 | Translated address is valid |
| fault_o | output | 1 | Access fault: offset out of range |
| paddr_o | output | 16 | Physical address, zero when not valid |

## Verification
Each segment of the reset table is tried at offset 0, at limit-1, at the limit and at the top of the offset range. These cases separate an off-by-one in the bound compare and a wrong segment select. Writes made together with a request to the same segment show whether the old or the new descriptor was used. Programmed limits of 0 and 0x4000, and a base near the top of memory, exercise the compare extremes and the wrap of the sum. A long run of mixed requests, idle cycles and writes is compared every cycle against a behavioural table model.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  // default descriptor layout loaded at reset
  function automatic logic [31:0] boot_base(int unsigned idx);
    case (idx)
      0: boot_base = 32'h4000;
      1: boot_base = 32'h4800;
      2: boot_base = 32'hF000;
      default: boot_base = 32'h0000;
    endcase
  endfunction

  function automatic logic [31:0] boot_limit(int unsigned idx);
    case (idx)
      0: boot_limit = 32'h0800;
      1: boot_limit = 32'h1400;
      2: boot_limit = 32'h1000;
      3: boot_limit = 32'h3000;
      default: boot_limit = 32'h0000;
    endcase
  endfunction
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int unsigned NSEG  = 4,
  parameter int unsigned IDX_W = 2,
  parameter int unsigned PA_W  = 16,
  parameter int unsigned LIM_W = 15
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [PA_W-1:0]            base_i,
  input  logic [LIM_W-1:0]           limit_i,
  output logic [NSEG-1:0][PA_W-1:0]  base_o,
  output logic [NSEG-1:0][LIM_W-1:0] limit_o
);
  import seg_xlate_pkg::*;

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic [31:0] rb, rl;
    assign rb = boot_base(g);
    assign rl = boot_limit(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[g]  <= rb[PA_W-1:0];
        limit_o[g] <= rl[LIM_W-1:0];
      end else if (we_i && (idx_i == IDX_W'(g))) begin
        base_o[g]  <= base_i;
        limit_o[g] <= limit_i;
      end
    end
  end
endmodule

// File: rtl/seg_check.sv
module seg_check #(
  parameter int unsigned OFF_W = 14,
  parameter int unsigned PA_W  = 16,
  parameter int unsigned LIM_W = 15
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             ok_o,
  output logic [PA_W-1:0]  pa_o
);
  // limit is exclusive: valid offsets are 0 .. limit-1
  assign ok_o = LIM_W'(off_i) < limit_i;
  assign pa_o = base_i + PA_W'(off_i);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int unsigned VA_W  = 16,
  parameter int unsigned SEG_W = 2,
  localparam int unsigned NSEG  = 1 << SEG_W,
  localparam int unsigned OFF_W = VA_W - SEG_W,
  localparam int unsigned LIM_W = OFF_W + 1,
  localparam int unsigned PA_W  = VA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic             desc_we_i,
  input  logic [SEG_W-1:0] desc_idx_i,
  input  logic [PA_W-1:0]  desc_base_i,
  input  logic [LIM_W-1:0] desc_limit_i,
  output logic             valid_o,
  output logic             fault_o,
  output logic [PA_W-1:0]  paddr_o
);
  logic [NSEG-1:0][PA_W-1:0]  base_all;
  logic [NSEG-1:0][LIM_W-1:0] limit_all;
  logic [SEG_W-1:0] seg;
  logic [OFF_W-1:0] off;
  logic             ok;
  logic [PA_W-1:0]  pa;

  seg_table #(.NSEG(NSEG), .IDX_W(SEG_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (desc_we_i),
    .idx_i   (desc_idx_i),
    .base_i  (desc_base_i),
    .limit_i (desc_limit_i),
    .base_o  (base_all),
    .limit_o (limit_all)
  );

  assign seg = vaddr_i[VA_W-1 -: SEG_W];
  assign off = vaddr_i[OFF_W-1:0];

  seg_check #(.OFF_W(OFF_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_check (
    .base_i  (base_all[seg]),
    .limit_i (limit_all[seg]),
    .off_i   (off),
    .ok_o    (ok),
    .pa_o    (pa)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      fault_o <= 1'b0;
      paddr_o <= '0;
    end else begin
      valid_o <= req_valid_i && ok;
      fault_o <= req_valid_i && !ok;
      paddr_o <= (req_valid_i && ok) ? pa : '0;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int unsigned PA_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            valid_o,
  input logic            fault_o,
  input logic [PA_W-1:0] paddr_o
);
  // R1: outputs cleared while in reset
  always @(negedge clk_i)
    if (!rst_ni) p_reset_clear_r1: assert (!valid_o && !fault_o && paddr_o == '0);

  p_fault_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!valid_o && paddr_o == '0));

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!valid_o && !fault_o));

  p_req_answer_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> $onehot({valid_o, fault_o}));

  p_addr_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> paddr_o == '0);
endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .valid_o     (valid_o),
  .fault_o     (fault_o),
  .paddr_o     (paddr_o)
);

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] va = '0;
  logic        we = 1'b0;
  logic [1:0]  widx = '0;
  logic [15:0] wbase = '0;
  logic [14:0] wlim = '0;
  logic        valid, fault;
  logic [15:0] paddr;

  int n_cmp = 0, n_bad = 0;
  int mbase[4];
  int mlim[4];

  always #2 clk = ~clk;

  seg_xlate dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req), .vaddr_i(va),
    .desc_we_i(we), .desc_idx_i(widx), .desc_base_i(wbase), .desc_limit_i(wlim),
    .valid_o(valid), .fault_o(fault), .paddr_o(paddr)
  );

  task automatic compare(string tag, bit ev, bit ef, int ea);
    n_cmp++;
    if (valid !== ev || fault !== ef || paddr !== 16'(ea)) begin
      n_bad++;
      $display("FAIL %s: got v=%0b f=%0b pa=%h, expected v=%0b f=%0b pa=%h",
               tag, valid, fault, paddr, ev, ef, 16'(ea));
    end
  endtask

  // one clock: drive, predict from model (pre-write), update model, check after edge
  task automatic cyc(string tag, bit r, int a, bit w = 0, int wi = 0, int wb = 0, int wl = 0);
    bit ev, ef;
    int ea, s, o;
    req = r; va = 16'(a); we = w; widx = 2'(wi); wbase = 16'(wb); wlim = 15'(wl);
    s = (a >> 14) & 3;
    o = a & 16'h3FFF;
    ev = 0; ef = 0; ea = 0;
    if (r) begin
      if (o < mlim[s]) begin ev = 1; ea = (mbase[s] + o) & 16'hFFFF; end
      else ef = 1;
    end
    if (w) begin mbase[wi] = wb & 16'hFFFF; mlim[wi] = wl & 16'h7FFF; end
    @(posedge clk); #1;
    compare(tag, ev, ef, ea);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int x;
    mbase = '{32'h4000, 32'h4800, 32'hF000, 32'h0000};
    mlim  = '{32'h0800, 32'h1400, 32'h1000, 32'h3000};
    #9;
    compare("R1 in reset", 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    compare("R1 after reset", 0, 0, 0);
    // R7 / R2 / R3 / R5: each default segment at 0, limit-1, limit, top
    for (int s = 0; s < 4; s++) begin
      cyc("R7 offset0", 1, (s << 14));
      cyc("R5 limit-1", 1, (s << 14) | (mlim[s] - 1));
      cyc("R5 at limit", 1, (s << 14) | mlim[s]);
      cyc("R4 top offset", 1, (s << 14) | 16'h3FFF);
    end
    cyc("R2 seg2 mid", 1, 16'h8ABC);
    cyc("R6 idle", 0, 16'h0000);
    cyc("R6 idle addr", 0, 16'h4005);
    // R8: same-cycle write sees old entry
    cyc("R8 same cycle", 1, 16'h4005, 1, 1, 16'h1000, 16'h0010);
    cyc("R8 next cycle", 1, 16'h4005);
    cyc("R8 new limit", 1, 16'h4010);
    cyc("R9 seg0 kept", 1, 16'h0123);
    cyc("R9 seg2 kept", 1, 16'h8FFF);
    cyc("R10 limit0 write", 0, 0, 1, 2, 16'h1234, 0);
    cyc("R10 limit0 fault", 1, 16'h8000);
    cyc("R10 full write", 0, 0, 1, 3, 16'hFFF0, 16'h4000);
    cyc("R10 full top", 1, 16'hFFFF);
    cyc("R3 wrap", 1, 16'hC020);
    // mixed run against model
    x = 16'h1ACE;
    for (int i = 0; i < 400; i++) begin
      x = (x * 1103 + 12345) & 16'hFFFF;
      if (i % 37 == 5)
        cyc("R8 mixed write", (x & 1), x, 1, (x >> 3) & 3, x ^ 16'h5A5A, (x >> 2) & 16'h7FFF);
      else
        cyc("R3 mixed", (i % 5) != 0, x);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule